// File: doc/BRIEF.md
# Duty-Cycled Telemetry Sequence Controller

This block is the master sequencer of a battery-powered sensor transmitter. It divides a single reference clock into system-clock enable strobes and runs a fixed routine over and over. First it powers the acquisition front end and waits for it to settle. It then converts four sensor channels one after another through an ADC start/done handshake, strobing each result into a sample memory. Next it powers the transmitter and lets it settle. It gates a PN chip clock for exactly one 65-bit packet, then drops the transmitter power. Last, it sleeps for a jumper-selected interval.

The ADC, the sample memory, the serializer and the RF stages sit outside the block. The block drives their power enables, the channel select, the strobes and the chip-clock enables. All of its logic runs on the reference clock. Every divided clock appears as a one-cycle enable, so the neighbouring logic stays in one clock domain. The sleep lengths are parameters given in system clocks, so a simulation can shorten them.

Top module: `telem_seq_ctrl`

## Requirements
- R1: `sys_tick` pulses once every 4 × 2^`clk_div_sel` reference clocks, giving periods of 4, 8, 16 and 32 for selects 0 to 3. All other outputs change only on the clock edge at which `sys_tick` is high, so each value lasts whole system periods.
- R2: `pn_tick` is high only in cycles where both `sys_tick` and `pn_clk_en` are high. During transmission it pulses on every system tick. `sp_tick` coincides with every 63rd `pn_tick` of a packet and with no other.
- R3: After reset and after each sleep, `acq_pwr_en` is high for exactly SETTLE_CLKS (1024) system periods before the first `adc_start`. An `adc_done` pulse inside that interval has no effect on its length.
- R4: Channels 0, 1, 2 and 3 are converted in that order. `adc_start` lasts one system period. `mem_wr` lasts one system period and follows in the period after the first system tick at which `adc_done` is seen high while waiting. The next channel's `adc_start` follows in the period right after `mem_wr`.
- R5: `chan_sel` holds the channel number from the `adc_start` period through that channel's `mem_wr` period.
- R6: In the system period after the channel-3 `mem_wr`, `acq_pwr_en` is low and `tx_pwr_en` is high. `tx_pwr_en` alone then stays high for exactly SETTLE_CLKS system periods before `pn_clk_en` rises.
- R7: `pn_clk_en` and `ser_shift_en` are high together, with `tx_pwr_en`, for exactly 65 × 63 = 4095 system periods, which contain 65 `sp_tick` pulses. `tx_pwr_en`, `pn_clk_en` and `ser_shift_en` all fall in the same system period.
- R8: After transmission, every enable stays low for a number of system periods set by `sleep_sel`: 0 gives SLEEP_LONG, 1 gives SLEEP_MID, 2 gives SLEEP_SHORT and 3 gives zero. `acq_pwr_en` then rises and the routine repeats.
- R9: While `rst_n` is low, every output is low. The first system period after reset has every enable low, and `acq_pwr_en` rises in the second.
- R10: `acq_pwr_en` and `tx_pwr_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div_sel | input | 2 | Static system-clock division select (÷1, ÷2, ÷4, ÷8 of the base) |
| sleep_sel | input | 2 | Static sleep-interval select |
| adc_done | input | 1 | Conversion finished, held high until the write strobe |
| sys_tick | output | 1 | One-cycle system-clock enable |
| pn_tick | output | 1 | Gated PN chip-clock enable |
| sp_tick | output | 1 | Spread-data clock enable (PN ÷ 63) |
| acq_pwr_en | output | 1 | Acquisition front-end power enable |
| tx_pwr_en | output | 1 | Transmitter power enable |
| pn_clk_en | output | 1 | PN clock gate enable |
| ser_shift_en | output | 1 | Serializer shift (serial) mode |
| adc_start | output | 1 | Conversion start, one system period |
| mem_wr | output | 1 | Sample-memory write strobe, one system period |
| chan_sel | output | 2 | Channel under conversion |

## Verification
The assertions assume that `clk_div_sel` and `sleep_sel` change only while reset is low. They also assume that `adc_done` rises only after an `adc_start` and stays high until the write strobe. The stimulus meets both assumptions: the select pins are changed only inside a reset pulse, and the ADC model raises its done line a random 0 to 4 system periods after it sees a start and drops it once it sees the strobe. The one exception is a single deliberate `adc_done` pulse during the acquisition settle wait, where the controller is not listening. It is there to show that the pulse leaves the wait unchanged.

// File: rtl/telem_pkg.sv
// Shared definitions for the telemetry sequence controller.
// Assumes nothing beyond SystemVerilog packages being compiled first.
package telem_pkg;

    // Sequencer phases, in the order the routine visits them.
    typedef enum logic [2:0] {
        ST_BOOT       = 3'd0,
        ST_ACQ_SETTLE = 3'd1,
        ST_CONV_START = 3'd2,
        ST_CONV_WAIT  = 3'd3,
        ST_CONV_WRITE = 3'd4,
        ST_TX_SETTLE  = 3'd5,
        ST_TX_RUN     = 3'd6,
        ST_SLEEP      = 3'd7
    } seq_state_t;

endpackage

// File: rtl/tsc_clk_gen.sv
// Base and system clock-enable generator.
// Divides the reference clock by BASE_DIV to form a base strobe, then
// divides the base strobe by 2^clk_div_sel to form sys_tick.
// Assumes clk_div_sel is static outside reset and 2^clk_div_sel <= MAX_SYS_DIV.
module tsc_clk_gen #(
    parameter int BASE_DIV    = 4,
    parameter int MAX_SYS_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_div_sel,
    output logic       sys_tick
);
    localparam int BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int DIV_W  = (MAX_SYS_DIV > 1) ? $clog2(MAX_SYS_DIV) : 1;

    logic [BASE_W-1:0] base_cnt;
    logic              base_tick;

    // Free-running base prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
        end else if (base_tick) begin
            base_cnt <= '0;
        end else begin
            base_cnt <= base_cnt + BASE_W'(1);
        end
    end

    // Base strobe on the last count of the prescaler.
    always_comb base_tick = (base_cnt == BASE_W'(BASE_DIV - 1));

    generate
        if (MAX_SYS_DIV > 1) begin : g_sys_div
            logic [DIV_W-1:0] div_cnt;
            logic [DIV_W-1:0] div_lim;

            // Terminal count for the selected division.
            always_comb div_lim = DIV_W'((32'd1 << clk_div_sel) - 32'd1);

            // Counts base strobes up to the selected limit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                end else if (base_tick) begin
                    if (div_cnt == div_lim) begin
                        div_cnt <= '0;
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
            end

            // System strobe when the base strobe lands on the terminal count.
            always_comb sys_tick = base_tick && (div_cnt == div_lim);
        end else begin : g_sys_direct
            // No further division configured.
            always_comb sys_tick = base_tick;
        end
    endgenerate

endmodule

// File: rtl/tsc_chip_clk.sv
// PN chip-clock gate and spread-data divider.
// pn_tick is the system strobe gated by pn_en; sp_tick marks every SP_DIV-th
// pn_tick since pn_en rose. The divider restarts whenever pn_en is low.
// Assumes pn_en changes only on system ticks.
module tsc_chip_clk #(
    parameter int SP_DIV = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_tick,
    input  logic pn_en,
    output logic pn_tick,
    output logic sp_tick
);
    localparam int SP_W = (SP_DIV > 1) ? $clog2(SP_DIV) : 1;

    logic [SP_W-1:0] sp_cnt;

    // Gate the chip clock with the transmit enable.
    always_comb pn_tick = sys_tick && pn_en;

    // Spread-data strobe on the last chip of each group.
    always_comb sp_tick = pn_tick && (sp_cnt == SP_W'(SP_DIV - 1));

    // Chip counter within one spread-data bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !pn_en) begin
            sp_cnt <= '0;
        end else if (sp_tick) begin
            sp_cnt <= '0;
        end else if (pn_tick) begin
            sp_cnt <= sp_cnt + SP_W'(1);
        end
    end

endmodule

// File: rtl/tsc_seq_fsm.sv
// Acquire / transmit / sleep sequencer.
// Advances only on sys_tick. One shared counter times the settle waits,
// the packet length (in sp_tick pulses) and the sleep interval.
// Assumes adc_done is held until the write strobe and sleep_sel is static.
module tsc_seq_fsm
    import telem_pkg::*;
#(
    parameter int SETTLE_CLKS = 1024,
    parameter int NUM_CHAN    = 4,
    parameter int PKT_BITS    = 65,
    parameter int SLEEP_LONG  = 7160000,
    parameter int SLEEP_MID   = 895000,
    parameter int SLEEP_SHORT = 111875
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sys_tick,
    input  logic                        sp_tick,
    input  logic                        adc_done,
    input  logic [1:0]                  sleep_sel,
    output logic                        acq_pwr_en,
    output logic                        tx_pwr_en,
    output logic                        pn_clk_en,
    output logic                        ser_shift_en,
    output logic                        adc_start,
    output logic                        mem_wr,
    output logic [$clog2(NUM_CHAN)-1:0] chan_sel
);
    localparam int CH_W  = $clog2(NUM_CHAN);
    localparam int MAX_A = (SETTLE_CLKS > PKT_BITS) ? SETTLE_CLKS : PKT_BITS;
    localparam int MAX_B = (SLEEP_LONG > SLEEP_MID) ? SLEEP_LONG : SLEEP_MID;
    localparam int MAX_C = (MAX_B > SLEEP_SHORT) ? MAX_B : SLEEP_SHORT;
    localparam int MAX_N = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W = $clog2(MAX_N + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] sleep_lim;
    logic [CH_W-1:0]  chan;

    // Sleep length picked by the jumper setting; code 3 means no sleep.
    always_comb begin
        case (sleep_sel)
            2'd0:    sleep_lim = CNT_W'(SLEEP_LONG);
            2'd1:    sleep_lim = CNT_W'(SLEEP_MID);
            2'd2:    sleep_lim = CNT_W'(SLEEP_SHORT);
            default: sleep_lim = '0;
        endcase
    end

    // Phase sequencing, counting and channel stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            cnt   <= '0;
            chan  <= '0;
        end else if (sys_tick) begin
            case (state)
                ST_BOOT: begin
                    state <= ST_ACQ_SETTLE;
                    cnt   <= '0;
                end
                ST_ACQ_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE_CLKS - 1)) begin
                        state <= ST_CONV_START;
                        cnt   <= '0;
                        chan  <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_CONV_START: state <= ST_CONV_WAIT;
                ST_CONV_WAIT: begin
                    if (adc_done) begin
                        state <= ST_CONV_WRITE;
                    end
                end
                ST_CONV_WRITE: begin
                    if (chan == CH_W'(NUM_CHAN - 1)) begin
                        state <= ST_TX_SETTLE;
                        cnt   <= '0;
                    end else begin
                        chan  <= chan + CH_W'(1);
                        state <= ST_CONV_START;
                    end
                end
                ST_TX_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE_CLKS - 1)) begin
                        state <= ST_TX_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_TX_RUN: begin
                    if (sp_tick) begin
                        if (cnt == CNT_W'(PKT_BITS - 1)) begin
                            cnt   <= '0;
                            state <= (sleep_lim == '0) ? ST_ACQ_SETTLE : ST_SLEEP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_SLEEP: begin
                    if (cnt == sleep_lim - CNT_W'(1)) begin
                        state <= ST_ACQ_SETTLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_BOOT;
            endcase
        end
    end

    // Output decode from the registered phase.
    always_comb begin
        acq_pwr_en   = (state == ST_ACQ_SETTLE) || (state == ST_CONV_START) ||
                       (state == ST_CONV_WAIT)  || (state == ST_CONV_WRITE);
        tx_pwr_en    = (state == ST_TX_SETTLE) || (state == ST_TX_RUN);
        pn_clk_en    = (state == ST_TX_RUN);
        ser_shift_en = (state == ST_TX_RUN);
        adc_start    = (state == ST_CONV_START);
        mem_wr       = (state == ST_CONV_WRITE);
        chan_sel     = chan;
    end

endmodule

// File: rtl/telem_seq_ctrl.sv
// Top of the duty-cycled telemetry sequence controller.
// Ties together the clock-enable generator, the chip-clock gate and the
// phase sequencer. Every divided clock is presented as a one-cycle enable.
// Assumes clk_div_sel and sleep_sel change only while rst_n is low.
module telem_seq_ctrl #(
    parameter int BASE_DIV    = 4,
    parameter int MAX_SYS_DIV = 8,
    parameter int SETTLE_CLKS = 1024,
    parameter int NUM_CHAN    = 4,
    parameter int SP_DIV      = 63,
    parameter int PKT_BITS    = 65,
    parameter int SLEEP_LONG  = 7160000,
    parameter int SLEEP_MID   = 895000,
    parameter int SLEEP_SHORT = 111875
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  clk_div_sel,
    input  logic [1:0]                  sleep_sel,
    input  logic                        adc_done,
    output logic                        sys_tick,
    output logic                        pn_tick,
    output logic                        sp_tick,
    output logic                        acq_pwr_en,
    output logic                        tx_pwr_en,
    output logic                        pn_clk_en,
    output logic                        ser_shift_en,
    output logic                        adc_start,
    output logic                        mem_wr,
    output logic [$clog2(NUM_CHAN)-1:0] chan_sel
);

    tsc_clk_gen #(
        .BASE_DIV    (BASE_DIV),
        .MAX_SYS_DIV (MAX_SYS_DIV)
    ) u_clk_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_div_sel (clk_div_sel),
        .sys_tick    (sys_tick)
    );

    tsc_chip_clk #(
        .SP_DIV   (SP_DIV)
    ) u_chip_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_tick (sys_tick),
        .pn_en    (pn_clk_en),
        .pn_tick  (pn_tick),
        .sp_tick  (sp_tick)
    );

    tsc_seq_fsm #(
        .SETTLE_CLKS  (SETTLE_CLKS),
        .NUM_CHAN     (NUM_CHAN),
        .PKT_BITS     (PKT_BITS),
        .SLEEP_LONG   (SLEEP_LONG),
        .SLEEP_MID    (SLEEP_MID),
        .SLEEP_SHORT  (SLEEP_SHORT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_tick     (sys_tick),
        .sp_tick      (sp_tick),
        .adc_done     (adc_done),
        .sleep_sel    (sleep_sel),
        .acq_pwr_en   (acq_pwr_en),
        .tx_pwr_en    (tx_pwr_en),
        .pn_clk_en    (pn_clk_en),
        .ser_shift_en (ser_shift_en),
        .adc_start    (adc_start),
        .mem_wr       (mem_wr),
        .chan_sel     (chan_sel)
    );

endmodule

// File: rtl/telem_seq_ctrl_chk.sv
// Property checker for the telemetry sequence controller, bound to the top.
// Observes ports only; keeps one register holding the channel seen at start.
module telem_seq_ctrl_chk #(
    parameter int NUM_CHAN = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sys_tick,
    input logic                        pn_tick,
    input logic                        sp_tick,
    input logic                        acq_pwr_en,
    input logic                        tx_pwr_en,
    input logic                        pn_clk_en,
    input logic                        ser_shift_en,
    input logic                        adc_start,
    input logic                        mem_wr,
    input logic [$clog2(NUM_CHAN)-1:0] chan_sel
);
    logic [$clog2(NUM_CHAN)-1:0] start_chan;

    // Remember the channel presented with the conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_chan <= '0;
        end else if (sys_tick && adc_start) begin
            start_chan <= chan_sel;
        end
    end

    AST_PWR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(acq_pwr_en && tx_pwr_en)); // R10
    AST_PN_GATED: assert property (@(posedge clk) disable iff (!rst_n) pn_tick |-> (sys_tick && pn_clk_en)); // R2
    AST_SP_FROM_PN: assert property (@(posedge clk) disable iff (!rst_n) sp_tick |-> pn_tick); // R2
    AST_PN_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n) pn_clk_en |-> (tx_pwr_en && ser_shift_en)); // R7
    AST_STROBE_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n) (adc_start || mem_wr) |-> acq_pwr_en); // R4
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> (chan_sel == start_chan)); // R5
    AST_OUT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$past(sys_tick) |-> $stable({acq_pwr_en, tx_pwr_en, pn_clk_en, ser_shift_en, adc_start, mem_wr, chan_sel})); // R1

endmodule

bind telem_seq_ctrl telem_seq_ctrl_chk #(
    .NUM_CHAN     (NUM_CHAN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_tick     (sys_tick),
    .pn_tick      (pn_tick),
    .sp_tick      (sp_tick),
    .acq_pwr_en   (acq_pwr_en),
    .tx_pwr_en    (tx_pwr_en),
    .pn_clk_en    (pn_clk_en),
    .ser_shift_en (ser_shift_en),
    .adc_start    (adc_start),
    .mem_wr       (mem_wr),
    .chan_sel     (chan_sel)
);

// File: tb/telem_seq_ctrl_tb_top.sv
// Bench for the telemetry sequence controller: a behavioural ADC with random
// done latency, phase-length measurement in system ticks, directed select sweep.
module telem_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 1024;
    localparam int SP_DIV     = 63;
    localparam int PKT        = 65;
    localparam int SL_LONG    = 200;
    localparam int SL_MID     = 120;
    localparam int SL_SHORT   = 50;
    localparam int WATCHDOG   = 199000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_div_sel = 2'd0;
    logic [1:0] sleep_sel = 2'd0;
    logic       adc_done = 1'b0;
    logic       sys_tick, pn_tick, sp_tick;
    logic       acq_pwr_en, tx_pwr_en, pn_clk_en, ser_shift_en;
    logic       adc_start, mem_wr;
    logic [1:0] chan_sel;

    int errors = 0;
    int checks = 0;
    int clk_count = 0;
    bit run_over = 1'b0;

    telem_seq_ctrl #(
        .SETTLE_CLKS  (SETTLE),
        .SP_DIV       (SP_DIV),
        .PKT_BITS     (PKT),
        .SLEEP_LONG   (SL_LONG),
        .SLEEP_MID    (SL_MID),
        .SLEEP_SHORT  (SL_SHORT)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_div_sel  (clk_div_sel),
        .sleep_sel    (sleep_sel),
        .adc_done     (adc_done),
        .sys_tick     (sys_tick),
        .pn_tick      (pn_tick),
        .sp_tick      (sp_tick),
        .acq_pwr_en   (acq_pwr_en),
        .tx_pwr_en    (tx_pwr_en),
        .pn_clk_en    (pn_clk_en),
        .ser_shift_en (ser_shift_en),
        .adc_start    (adc_start),
        .mem_wr       (mem_wr),
        .chan_sel     (chan_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) clk_count <= clk_count + 1;

    function automatic int exp_period(input int sel);
        return 4 << sel;
    endfunction

    function automatic int exp_sleep(input int sel);
        case (sel)
            0:       return SL_LONG;
            1:       return SL_MID;
            2:       return SL_SHORT;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Advance to the next negedge at which sys_tick is high; R2 gating between ticks.
    task automatic next_tick;
        do begin
            @(negedge clk);
            if (sys_tick !== 1'b1 && pn_tick !== 1'b0)
                chk(1'b0, "R2 pn_tick off a system tick", pn_tick, 0);
        end while (sys_tick !== 1'b1);
    endtask

    // Reset with new static selects; R9 outputs low during reset.
    task automatic do_reset(input int dsel, input int ssel);
        @(negedge clk);
        rst_n = 1'b0;
        adc_done = 1'b0;
        clk_div_sel = 2'(dsel);
        sleep_sel = 2'(ssel);
        repeat (5) @(negedge clk);
        chk({acq_pwr_en, tx_pwr_en, pn_clk_en, ser_shift_en, adc_start, mem_wr, chan_sel,
             pn_tick, sp_tick, sys_tick} == '0, "R9 outputs in reset",
            {acq_pwr_en, tx_pwr_en, pn_clk_en, ser_shift_en, adc_start, mem_wr}, 0);
        rst_n = 1'b1;
    endtask

    // R1 system tick spacing in reference clocks.
    task automatic measure_period(input int dsel);
        int t0;
        do_reset(dsel, 3);
        next_tick;
        t0 = clk_count;
        next_tick;
        chk(clk_count - t0 == exp_period(dsel), "R1 system period", clk_count - t0, exp_period(dsel));
    endtask

    // R9 boot period then acquisition power.
    task automatic boot_check;
        next_tick;
        chk(!acq_pwr_en && !tx_pwr_en, "R9 boot period enables", acq_pwr_en, 0);
        next_tick;
        chk(acq_pwr_en == 1'b1, "R9 acquisition after boot", acq_pwr_en, 1);
    endtask

    // One full routine, starting at the first acquisition-settle tick.
    task automatic run_cycle(input int ssel);
        int n, p, s;
        n = 0;
        while (acq_pwr_en && !adc_start && n < 4000) begin
            n++;
            if (n == 100) adc_done = 1'b1;   // stray done, must be ignored (R3)
            if (n == 101) adc_done = 1'b0;
            next_tick;
        end
        adc_done = 1'b0;
        chk(n == SETTLE, "R3 acquisition settle length", n, SETTLE);
        for (int ch = 0; ch < 4; ch++) begin
            int d, k, ek;
            bit seen;
            chk(adc_start && chan_sel == 2'(ch), "R4 start order", chan_sel, ch);
            d = $urandom_range(0, 4);
            ek = (d == 0) ? 2 : d + 1;
            if (d == 0) adc_done = 1'b1;
            k = 0;
            seen = 1'b0;
            while (!seen && k < 20) begin
                next_tick;
                k++;
                if (k == d) adc_done = 1'b1;
                chk(chan_sel == 2'(ch), "R5 channel held", chan_sel, ch);
                if (mem_wr) seen = 1'b1;
                else chk(!adc_start, "R4 start lasts one period", adc_start, 0);
            end
            chk(k == ek, "R4 write strobe timing", k, ek);
            adc_done = 1'b0;
            next_tick;
            chk(!mem_wr, "R4 write lasts one period", mem_wr, 0);
        end
        chk(!acq_pwr_en && tx_pwr_en, "R6 handover to transmit", {acq_pwr_en, tx_pwr_en}, 1);
        chk(!(acq_pwr_en && tx_pwr_en), "R10 enables exclusive", {acq_pwr_en, tx_pwr_en}, 1);
        n = 0;
        while (tx_pwr_en && !pn_clk_en && n < 4000) begin
            n++;
            next_tick;
        end
        chk(n == SETTLE, "R6 transmit settle length", n, SETTLE);
        p = 0;
        s = 0;
        while (pn_clk_en && p < 5000) begin
            chk(ser_shift_en && tx_pwr_en && pn_tick && !acq_pwr_en, "R7 transmit enables",
                {ser_shift_en, tx_pwr_en, pn_tick}, 7);
            p++;
            chk(sp_tick == (p % SP_DIV == 0), "R2 spread clock spacing", sp_tick, (p % SP_DIV == 0));
            if (sp_tick) s++;
            next_tick;
        end
        chk(p == PKT * SP_DIV, "R7 packet length in chips", p, PKT * SP_DIV);
        chk(s == PKT, "R7 spread clocks per packet", s, PKT);
        chk(!tx_pwr_en && !ser_shift_en, "R7 enables drop together", {tx_pwr_en, ser_shift_en}, 0);
        n = 0;
        while (!acq_pwr_en && n < 1000) begin
            chk(!tx_pwr_en && !pn_clk_en && !pn_tick, "R8 quiet during sleep", tx_pwr_en, 0);
            n++;
            next_tick;
        end
        chk(n == exp_sleep(ssel), "R8 sleep length", n, exp_sleep(ssel));
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int dsel = 0; dsel < 4; dsel++) measure_period(dsel);
        do_reset(0, 0); boot_check; run_cycle(0);
        do_reset(0, 1); boot_check; run_cycle(1);
        do_reset(0, 2); boot_check; run_cycle(2);
        do_reset(0, 3); boot_check; run_cycle(3); run_cycle(3);
        run_over = 1'b1;
        summary;
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!run_over) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", clk_count, WATCHDOG);
            summary;
            $finish;
        end
    end

endmodule